// File: doc/BRIEF.md
# Grouped-Priority Interrupt Status Controller

This block collects level-sensitive request lines from thirteen peripherals into one 32-bit pending-status word, where each source owns a fixed bit. A 32-bit enable word sits beside it. The host reads and writes both words through a plain word-wide register port. The block reduces the enabled pending bits to a 3-bit processor priority code. The sources fall into three fixed groups, at levels 3, 5 and 6, and the highest group that has an enabled pending bit sets the code.

A status bit is updated on transitions of its request line. A rising request sets the bit and a falling request clears it. Between transitions the host may overwrite the word freely. A separate control strobe, meant for a disk control register, can force the disk-DMA bit (bit 26) on or off. The register port has no handshake. It accepts a write in any cycle, and read data is combinational from the selected address.

Top module: `irq_group_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status word and the enable word are both 0 and `cpu_level` is 0.
- R2: A rising edge on `irq_req[i]` sets the matching status bit at the next clock edge. The mapping from index to bit is: 0→7, 1→3, 2→2, 3→9, 4→10, 5→12, 6→5, 7→17, 8→28, 9→27, 10→26, 11→23, 12→21.
- R3: A falling edge on `irq_req[i]` clears the matching status bit at the next clock edge.
- R4: When `host_wr` is high, address 0x7000 replaces the status word and address 0x7000+0x800 (0x7800) replaces the enable word at the next edge. `host_rdata` shows the word at `host_addr` in the same cycle. Every other address reads as 0, and writes to it change nothing.
- R5: A host write to the status word wins over a request edge or a force strobe in the same cycle.
- R6: `cpu_level` is 6 if any enabled pending bit lies in the group {28,27,26,23,21}. Otherwise it is 5 if bit 17 is enabled and pending. Otherwise it is 3 if any enabled pending bit lies in {7,3,2,9,10,12,5}. Otherwise it is 0.
- R7: An enable bit of 1 lets its status bit take part in R6. Writing the enable word never changes the status word.
- R8: When `dma_ctl_stb` is high, status bit 26 takes the value of `dma_ctl_on` at the next edge. This overrides a same-cycle edge on `irq_req[10]`.
- R9: Status bits outside all three groups can be set by the host but never raise `cpu_level`.
- R10: A request held steady does not rewrite its bit. A bit that the host clears while its request stays high remains clear until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 16 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr` |
| irq_req | input | 13 | Peripheral request lines |
| dma_ctl_stb | input | 1 | Force strobe for status bit 26 |
| dma_ctl_on | input | 1 | Value forced into bit 26 |
| cpu_level | output | 3 | Encoded processor priority level |

## Verification
The assertions check several properties on every cycle. Each request edge must move its own status bit. A host status write must land unchanged, and the force strobe must land on bit 26. An enable write alone must leave the status word still. The level must always be one of the four legal codes, and a non-zero level requires an enabled pending bit. The bench scenarios show the parts that need a planned history. These are the group precedence under changing enables, the lost-edge behaviour after a host clear while a request is held high, the three-way same-cycle collisions, and the ignored addresses.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_SRC   = 13;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 16;
  localparam int BIT_W     = $clog2(DATA_W);
  localparam logic [ADDR_W-1:0] STAT_ADDR = 16'h7000;
  localparam logic [ADDR_W-1:0] ENAB_ADDR = 16'h7800;
  localparam int FORCE_BIT = 26;

  // Bit position owned by each request index
  function automatic int src_bit(input int idx);
    case (idx)
      0: return 7;   1: return 3;   2: return 2;   3: return 9;
      4: return 10;  5: return 12;  6: return 5;   7: return 17;
      8: return 28;  9: return 27;  10: return 26; 11: return 23;
      default: return 21;
    endcase
  endfunction

  // Priority group of each request index
  function automatic logic [2:0] src_group(input int idx);
    if (idx <= 6) return 3'd3;
    else if (idx == 7) return 3'd5;
    else return 3'd6;
  endfunction

  function automatic logic [DATA_W-1:0] group_bits(input logic [2:0] grp);
    logic [DATA_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (src_group(i) == grp) acc[src_bit(i)] = 1'b1;
    return acc;
  endfunction
endpackage

// File: rtl/irqc_edge.sv
module irqc_edge
  import irqc_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= req;
  end

  for (genvar i = 0; i < N; i++) begin : g_det
    assign rise[i] = req[i] & ~prev_q[i];
    assign fall[i] = ~req[i] & prev_q[i];
  end
endmodule

// File: rtl/irqc_status.sv
module irqc_status
  import irqc_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  rise,
  input  logic [N-1:0]  fall,
  input  logic          frc_stb,
  input  logic          frc_val,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] status_q
);
  logic [DW-1:0] set_v, clr_v, nxt;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    for (int i = 0; i < N; i++) begin
      set_v[src_bit(i)] = rise[i];
      clr_v[src_bit(i)] = fall[i];
    end
  end

  always_comb begin
    nxt = (status_q | set_v) & ~clr_v;
    if (frc_stb) nxt[FORCE_BIT] = frc_val;
    if (wr_en)   nxt = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= nxt;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> status_q == '0);

  p_host_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> status_q == $past(wr_data));

  p_force_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_stb && !wr_en) |=> status_q[FORCE_BIT] == $past(frc_val));

  for (genvar i = 0; i < N; i++) begin : g_chk
    localparam int B = src_bit(i);
    localparam bit FB = (B == FORCE_BIT);
    p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rise[i] && !wr_en && !(frc_stb && FB)) |=> status_q[B]);
    p_fall_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fall[i] && !wr_en && !(frc_stb && FB)) |=> !status_q[B]);
  end
endmodule

// File: rtl/irqc_level.sv
module irqc_level
  import irqc_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] status,
  input  logic [DW-1:0] enab,
  output logic [2:0]    level
);
  localparam logic [2:0] GRP [3] = '{3'd6, 3'd5, 3'd3};
  logic [DW-1:0] live;
  logic [2:0]    hit;

  assign live = status & enab;

  for (genvar g = 0; g < 3; g++) begin : g_grp
    localparam logic [DW-1:0] GM = group_bits(GRP[g]);
    assign hit[g] = |(live & GM);
  end

  always_comb begin
    if (hit[0])      level = GRP[0];
    else if (hit[1]) level = GRP[1];
    else if (hit[2]) level = GRP[2];
    else             level = 3'd0;
  end

  p_level_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    level inside {3'd0, 3'd3, 3'd5, 3'd6});

  p_level_needs_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (level != 3'd0) |-> (live != '0));
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
  import irqc_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic [N-1:0]  irq_req,
  input  logic          dma_ctl_stb,
  input  logic          dma_ctl_on,
  output logic [2:0]    cpu_level
);
  logic [N-1:0]  rise, fall;
  logic [DW-1:0] status_q, enab_q;
  logic          sel_stat, sel_enab;

  assign sel_stat = (host_addr == STAT_ADDR);
  assign sel_enab = (host_addr == ENAB_ADDR);

  irqc_edge #(.N(N)) u_edge (
    .clk(clk), .rst_n(rst_n), .req(irq_req), .rise(rise), .fall(fall)
  );

  irqc_status #(.N(N), .DW(DW)) u_stat (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .frc_stb(dma_ctl_stb), .frc_val(dma_ctl_on),
    .wr_en(host_wr && sel_stat), .wr_data(host_wdata),
    .status_q(status_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                enab_q <= '0;
    else if (host_wr && sel_enab) enab_q <= host_wdata;
  end

  always_comb begin
    if (sel_stat)      host_rdata = status_q;
    else if (sel_enab) host_rdata = enab_q;
    else               host_rdata = '0;
  end

  irqc_level #(.DW(DW)) u_lvl (
    .clk(clk), .rst_n(rst_n), .status(status_q), .enab(enab_q),
    .level(cpu_level)
  );

  p_enab_reset_r1: assert property (@(posedge clk)
    !rst_n |=> enab_q == '0);

  p_enab_keeps_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && sel_enab && rise == '0 && fall == '0 && !dma_ctl_stb)
      |=> $stable(status_q));

  p_stray_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !sel_stat && !sel_enab) |=> $stable(enab_q));
endmodule

// File: tb/test_irq_group_ctrl.sv
module test_irq_group_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [15:0] host_addr = 16'h0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [12:0] irq_req = '0;
  logic        dma_ctl_stb = 1'b0;
  logic        dma_ctl_on = 1'b0;
  logic [2:0]  cpu_level;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [15:0] A_ST = 16'h7000;
  localparam logic [15:0] A_EN = 16'h7800;

  always #10 clk = ~clk;

  irq_group_ctrl i_irq_group_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_req(irq_req),
    .dma_ctl_stb(dma_ctl_stb), .dma_ctl_on(dma_ctl_on), .cpu_level(cpu_level)
  );

  // {requests[12:0], enable[31:0], expected status[31:0], expected level[2:0]}
  localparam int NV = 11;
  localparam logic [79:0] TBL [NV] = '{
    {13'h0002, 32'hFFFF_FFFF, 32'h0000_0008, 3'd3},
    {13'h0082, 32'hFFFF_FFFF, 32'h0002_0008, 3'd5},
    {13'h0482, 32'hFFFF_FFFF, 32'h0402_0008, 3'd6},
    {13'h0482, 32'h0002_0008, 32'h0402_0008, 3'd5},
    {13'h0482, 32'h0000_0008, 32'h0402_0008, 3'd3},
    {13'h0482, 32'h0000_0000, 32'h0402_0008, 3'd0},
    {13'h0400, 32'hFFFF_FFFF, 32'h0400_0000, 3'd6},
    {13'h0000, 32'hFFFF_FFFF, 32'h0000_0000, 3'd0},
    {13'h1FFF, 32'hFFFF_FFFF, 32'h1CA2_16AC, 3'd6},
    {13'h1FFF, 32'h0000_FFFF, 32'h1CA2_16AC, 3'd3},
    {13'h0000, 32'hFFFF_FFFF, 32'h0000_0000, 3'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(A_ST, d); chk("R1 status", d, 32'h0);
    rd(A_EN, d); chk("R1 enable", d, 32'h0);
    chk("R1 level", {29'b0, cpu_level}, 32'h0);

    // Table: R2 R3 R6 R7
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      irq_req = TBL[k][79:67];
      host_wr = 1'b1; host_addr = A_EN; host_wdata = TBL[k][66:35];
      @(negedge clk);
      host_wr = 1'b0;
      rd(A_ST, d); chk($sformatf("R2/R3 status vec %0d", k), d, TBL[k][34:3]);
      chk($sformatf("R6/R7 level vec %0d", k), {29'b0, cpu_level}, {29'b0, TBL[k][2:0]});
    end

    // R9 and R4: ungrouped bit, stray address
    wr(A_ST, 32'h0000_0100);
    rd(A_ST, d); chk("R4 status readback", d, 32'h0000_0100);
    chk("R9 ungrouped level", {29'b0, cpu_level}, 32'h0);
    wr(16'h1234, 32'hDEAD_BEEF);
    rd(A_ST, d); chk("R4 stray write status", d, 32'h0000_0100);
    rd(A_EN, d); chk("R4 stray write enable", d, 32'hFFFF_FFFF);
    rd(16'h1234, d); chk("R4 stray read", d, 32'h0);
    wr(A_ST, 32'h0);

    // R5 host write beats rising edge; R10 held request does not re-set
    @(negedge clk);
    irq_req[1] = 1'b1; host_wr = 1'b1; host_addr = A_ST; host_wdata = 32'h0;
    @(negedge clk);
    host_wr = 1'b0;
    rd(A_ST, d); chk("R5 write beats edge", d, 32'h0);
    @(negedge clk);
    rd(A_ST, d); chk("R10 held request stays clear", d, 32'h0);
    chk("R10 level", {29'b0, cpu_level}, 32'h0);
    irq_req[1] = 1'b0;
    @(negedge clk);
    irq_req[1] = 1'b1;
    @(negedge clk);
    rd(A_ST, d); chk("R10 new edge sets", d, 32'h0000_0008);
    irq_req[1] = 1'b0;
    @(negedge clk);
    rd(A_ST, d); chk("R3 clear again", d, 32'h0);

    // R8 force path
    @(negedge clk);
    dma_ctl_stb = 1'b1; dma_ctl_on = 1'b1;
    @(negedge clk);
    dma_ctl_stb = 1'b0;
    rd(A_ST, d); chk("R8 force on", d, 32'h0400_0000);
    chk("R8 level", {29'b0, cpu_level}, 32'h6);
    irq_req[10] = 1'b1; dma_ctl_stb = 1'b1; dma_ctl_on = 1'b0;
    @(negedge clk);
    dma_ctl_stb = 1'b0;
    rd(A_ST, d); chk("R8 force off beats edge", d, 32'h0);
    dma_ctl_stb = 1'b1; dma_ctl_on = 1'b1;
    host_wr = 1'b1; host_addr = A_ST; host_wdata = 32'h0000_0001;
    @(negedge clk);
    dma_ctl_stb = 1'b0; host_wr = 1'b0;
    rd(A_ST, d); chk("R5 write beats force", d, 32'h0000_0001);
    irq_req[10] = 1'b0;
    @(negedge clk);

    // R1 reset again with state present
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(A_ST, d); chk("R1 status after reset", d, 32'h0);
    rd(A_EN, d); chk("R1 enable after reset", d, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule